// File: doc/BRIEF.md
# Element-Serial Vector Execution Unit

This block is the datapath of a small vector coprocessor. It holds eight vector registers, each made of 64 elements of 64 bits. One instruction names a destination, two source registers and an operation, and the unit applies that operation to all 64 element positions. A single shared arithmetic unit does the work, one element per clock. Each position i produces result element i.

Two operand forms are supported. In vector-vector form the second operand is element i of a second register. In vector-scalar form one 64-bit scalar, taken with the instruction, is used at every position. Arithmetic is two's-complement and wraps at 64 bits.

Instructions arrive over a valid/ready handshake. A one-cycle done pulse marks the end of each instruction. An element access port lets the surrounding logic or a bench write elements while the unit is idle, and read any element at any time.

Top module: `vec_unit`

## Requirements
- R1: After reset, in_ready_o is 1 and done_o is 0.
- R2: An instruction is accepted on a rising edge where in_valid_i and in_ready_o are both 1. in_ready_o is 0 from the cycle after acceptance through the cycle before done_o rises. in_valid_i has no effect while in_ready_o is 0.
- R3: In vector-vector form (form_i = 0), dst[i] = srcA[i] op srcB[i] for every i from 0 to 63.
- R4: In vector-scalar form (form_i = 1), dst[i] = srcA[i] op scalar_i for every i from 0 to 63.
- R5: op_i encodings: 2'b00 is add, 2'b01 is subtract (A minus B), 2'b10 is multiply (low 64 bits of the product), and 2'b11 acts as add. All results wrap modulo 2^64.
- R6: If an instruction is accepted at edge k, done_o is 1 for exactly one cycle, the cycle after edge k+64. in_ready_o is 1 in that same cycle, so a new instruction can be accepted there.
- R7: The destination may equal either source or both sources. Results equal the operation applied to the pre-instruction source values.
- R8: While idle, acc_we_i = 1 writes acc_wdata_i to element acc_idx_i of register acc_reg_i. acc_rdata_o always shows that element combinationally.
- R9: acc_we_i has no effect while an instruction is in progress.
- R10: The instruction fields are captured at acceptance. Changes to op_i, form_i, dst_i, srca_i, srcb_i and scalar_i while busy do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Unit idle, able to accept an instruction |
| op_i | input | 2 | Operation code |
| form_i | input | 1 | 0 = vector-vector, 1 = vector-scalar |
| dst_i | input | 3 | Destination register index |
| srca_i | input | 3 | First source register index |
| srcb_i | input | 3 | Second source register index |
| scalar_i | input | 64 | Scalar operand for vector-scalar form |
| done_o | output | 1 | One-cycle completion pulse |
| acc_we_i | input | 1 | Element write strobe (idle only) |
| acc_reg_i | input | 3 | Register index for element access |
| acc_idx_i | input | 6 | Element index for element access |
| acc_wdata_i | input | 64 | Element write data |
| acc_rdata_o | output | 64 | Element read data |

## Verification
The bench fills all registers with random values plus extreme values (all ones, the sign bit, zero), so that carries, borrows and product truncation show up in the low 64 bits. It runs each operation in both forms, and a wrong scalar broadcast or a wrong source selection gives a different result. In-place cases use a destination equal to one source or to both sources, which exposes any write that lands before the matching read. A back-to-back issue in the done cycle and field scrambling while busy test the handshake and the capture of the instruction fields. An access write attempted while busy tests that such writes are blocked.

// File: rtl/vec_pkg.sv
package vec_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_ALT = 2'b11
  } vop_e;

  typedef struct packed {
    vop_e        op;
    logic        form;
    logic [2:0]  dst;
    logic [2:0]  sa;
    logic [2:0]  sb;
    logic [63:0] scalar;
  } vinstr_t;
endpackage

// File: rtl/vec_alu.sv
module vec_alu
  import vec_pkg::*;
#(
  parameter int DW = 64
) (
  input  vop_e          op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] sum, dif, prd;

  assign sum = a_i + b_i;
  assign dif = a_i - b_i;
  assign prd = a_i * b_i; // low DW bits only

  always_comb begin
    unique case (op_i)
      OP_SUB:  y_o = dif;
      OP_MUL:  y_o = prd;
      default: y_o = sum;
    endcase
  end
endmodule

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int DW    = 64,
  parameter int DEPTH = 512,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/vec_seq.sv
module vec_seq
  import vec_pkg::*;
#(
  parameter int NELEMS = 64,
  localparam int IW    = $clog2(NELEMS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  input  vinstr_t       instr_i,
  output vinstr_t       instr_o,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(NELEMS - 1);

  logic          busy_q, done_q;
  logic [IW-1:0] idx_q;
  vinstr_t       instr_q;
  logic          accept, last;

  assign ready_o = !busy_q;
  assign accept  = valid_i && !busy_q;
  assign last    = busy_q && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      instr_q <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        instr_q <= instr_i;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign instr_o = instr_q;
  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;

  AST_ACCEPT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (busy_q && idx_q == '0)); // R2
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST) |=> (busy_q && idx_q == $past(idx_q) + 1'b1)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == LAST) |=> (done_q && ready_o)); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_INSTR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST) |=> $stable(instr_q)); // R10
endmodule

// File: rtl/vec_unit.sv
module vec_unit
  import vec_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int NELEMS = 64,
  parameter int DW     = 64,
  localparam int RW    = $clog2(NREGS),
  localparam int IW    = $clog2(NELEMS),
  localparam int AW    = RW + IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [1:0]    op_i,
  input  logic          form_i,
  input  logic [RW-1:0] dst_i,
  input  logic [RW-1:0] srca_i,
  input  logic [RW-1:0] srcb_i,
  input  logic [DW-1:0] scalar_i,
  output logic          done_o,
  input  logic          acc_we_i,
  input  logic [RW-1:0] acc_reg_i,
  input  logic [IW-1:0] acc_idx_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic [DW-1:0] acc_rdata_o
);
  localparam int NRD = 3;

  vinstr_t       in_instr, cur;
  logic          busy;
  logic [IW-1:0] idx;
  logic [AW-1:0] raddr [NRD];
  logic [DW-1:0] rdata [NRD];
  logic [DW-1:0] opb, res;
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  always_comb begin
    in_instr        = '0;
    in_instr.op     = vop_e'(op_i);
    in_instr.form   = form_i;
    in_instr.dst    = dst_i;
    in_instr.sa     = srca_i;
    in_instr.sb     = srcb_i;
    in_instr.scalar = scalar_i;
  end

  vec_seq #(.NELEMS(NELEMS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .ready_o (in_ready_o),
    .instr_i (in_instr),
    .instr_o (cur),
    .busy_o  (busy),
    .idx_o   (idx),
    .done_o  (done_o)
  );

  assign raddr[0] = {cur.sa, idx};
  assign raddr[1] = {cur.sb, idx};
  assign raddr[2] = {acc_reg_i, acc_idx_i};

  assign opb = cur.form ? cur.scalar : rdata[1];

  vec_alu #(.DW(DW)) u_alu (
    .op_i (cur.op),
    .a_i  (rdata[0]),
    .b_i  (opb),
    .y_o  (res)
  );

  // sequencer owns the write port while busy; access writes are dropped then
  assign rf_we    = busy || acc_we_i;
  assign rf_waddr = busy ? {cur.dst, idx} : {acc_reg_i, acc_idx_i};
  assign rf_wdata = busy ? res : acc_wdata_i;

  vec_regfile #(.DW(DW), .DEPTH(NREGS * NELEMS), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign acc_rdata_o = rdata[2];

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> (done_o || !in_ready_o)); // R2
endmodule

// File: tb/tb_vec_unit.sv
`timescale 1ns/1ps
module tb_vec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = '0;
  logic        form = 1'b0;
  logic [2:0]  dst = '0, sa = '0, sb = '0;
  logic [63:0] scalar = '0;
  logic        done;
  logic        acc_we = 1'b0;
  logic [2:0]  acc_reg = '0;
  logic [5:0]  acc_idx = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [63:0] ref_m [8][64];

  always #2.5 clk = ~clk;

  vec_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .form_i(form), .dst_i(dst), .srca_i(sa), .srcb_i(sb),
    .scalar_i(scalar), .done_o(done), .acc_we_i(acc_we), .acc_reg_i(acc_reg),
    .acc_idx_i(acc_idx), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] apply(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
    case (o)
      2'b01:   return a - b;
      2'b10:   return a * b;
      default: return a + b;
    endcase
  endfunction

  // tasks start and end right after a falling edge
  task automatic acc_write(input int r, input int i, input logic [63:0] v);
    acc_we = 1'b1; acc_reg = 3'(r); acc_idx = 6'(i); acc_wdata = v;
    @(negedge clk);
    acc_we = 1'b0;
    ref_m[r][i] = v;
  endtask

  task automatic read_chk(input int r, input int i, input string req);
    acc_reg = 3'(r); acc_idx = 6'(i);
    #1;
    chk(acc_rdata === ref_m[r][i], req, acc_rdata, ref_m[r][i]);
  endtask

  task automatic check_reg(input int r, input string req);
    for (int i = 0; i < 64; i++) read_chk(r, i, req);
  endtask

  task automatic exec(input logic [1:0] o, input bit f, input int d, input int a, input int b,
                      input logic [63:0] s, input string req);
    logic [63:0] tmp [64];
    int spare;
    spare = (d + 1) % 8;
    if (spare == a || spare == b) spare = (d + 3) % 8;
    for (int i = 0; i < 64; i++) tmp[i] = apply(o, ref_m[a][i], f ? s : ref_m[b][i]);
    chk(in_ready === 1'b1, "R2", 64'(in_ready), 64'd1);
    in_valid = 1'b1; op = o; form = f; dst = 3'(d); sa = 3'(a); sb = 3'(b); scalar = s;
    @(posedge clk);
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      if (c == 0) begin
        // R10: scramble fields while busy; R2: valid held high has no effect
        op = 2'($urandom); form = ~f; dst = 3'($urandom); sa = 3'($urandom);
        sb = 3'($urandom); scalar = {$urandom, $urandom};
      end
      if (c == 1) in_valid = 1'b0;
      chk(in_ready === 1'b0 && done === 1'b0, "R2/R6 busy", {in_ready, done}, 64'd0);
      if (c == 10) begin
        acc_we = 1'b1; acc_reg = 3'(spare); acc_idx = 6'd5; acc_wdata = ~ref_m[spare][5];
      end
      if (c == 11) acc_we = 1'b0;
    end
    @(negedge clk);
    chk(done === 1'b1 && in_ready === 1'b1, "R6 done", {in_ready, done}, 64'd3);
    for (int i = 0; i < 64; i++) ref_m[d][i] = tmp[i];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && done === 1'b0, "R1 in reset", {in_ready, done}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && done === 1'b0, "R1", {in_ready, done}, 64'd2);

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) acc_write(r, i, {$urandom, $urandom});
    acc_write(0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    acc_write(1, 0, 64'h1);
    acc_write(0, 1, 64'h8000_0000_0000_0000);
    acc_write(1, 1, 64'h8000_0000_0000_0000);
    acc_write(0, 2, 64'h0);
    acc_write(1, 2, 64'h1);
    acc_write(0, 3, 64'hFFFF_FFFF_0000_0001);
    acc_write(1, 3, 64'h0000_0001_FFFF_FFFF);
    for (int r = 0; r < 8; r++) check_reg(r, "R8");

    exec(2'b00, 1'b0, 2, 0, 1, 64'd0, "R3 add");
    check_reg(2, "R3/R5 vv add R10");
    read_chk(3, 5, "R9");
    exec(2'b01, 1'b0, 3, 0, 1, 64'd0, "R3 sub");
    check_reg(3, "R3/R5 vv sub R10");
    read_chk(4, 5, "R9");
    exec(2'b10, 1'b0, 4, 0, 1, 64'd0, "R3 mul");
    check_reg(4, "R3/R5 vv mul R10");
    exec(2'b00, 1'b1, 5, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 add");
    check_reg(5, "R4/R5 vs add");
    exec(2'b01, 1'b1, 6, 0, 7, 64'h1234_5678_9ABC_DEF0, "R4 sub");
    check_reg(6, "R4/R5 vs sub");
    exec(2'b10, 1'b1, 7, 0, 0, 64'hDEAD_BEEF_0000_0003, "R4 mul");
    check_reg(7, "R4/R5 vs mul");
    exec(2'b11, 1'b0, 5, 2, 3, 64'd0, "R5 alt");
    check_reg(5, "R5 op 11 as add");

    exec(2'b00, 1'b0, 0, 0, 1, 64'd0, "R7");
    check_reg(0, "R7 dst=srcA");
    exec(2'b10, 1'b0, 1, 1, 1, 64'd0, "R7");
    check_reg(1, "R7 dst=srcA=srcB");
    exec(2'b01, 1'b1, 6, 6, 6, 64'h7, "R7");
    check_reg(6, "R7 vs in place");

    // R6: back-to-back issue in the done cycle
    exec(2'b00, 1'b0, 2, 3, 4, 64'd0, "R6 first");
    exec(2'b01, 1'b0, 3, 2, 4, 64'd0, "R6 second");
    for (int r = 0; r < 8; r++) check_reg(r, "R6/R8 final");

    @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R6 idle", {in_ready, done}, 64'd2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule